// File: doc/BRIEF.md
# AXI4 Per-Beat Data Delay Slice

This slice sits between an AXI4 master and an AXI4 slave. It adds a fixed latency to every single data beat on the write-data and read-data channels. The delay applies to each beat of a burst in turn, so a burst is not delayed only once as a whole. A beat is taken into a one-entry holding stage, and a counter then runs for `DELAY` cycles (15 by default). After that the beat is offered downstream and held there until the receiver takes it.

The write-address, read-address and write-response channels are wired straight through. Address acceptance therefore never waits on the data delay, and the master may keep as many transactions outstanding as the slave allows. Each data direction holds at most one beat at a time. A burst of N beats therefore takes at least N×(DELAY+1) cycles. The slice is used to model a slow memory or interconnect, or to stretch data timing in a system under test.

Top module: `axi_beat_delay_slice`

## Requirements
- R1: A write-data beat accepted on the master side in cycle n raises `m_wvalid` in cycle n+DELAY (n+15 by default), and never earlier. This holds for every beat of a burst.
- R2: A read-data beat accepted on the slave side in cycle n raises `s_rvalid` in cycle n+DELAY, and never earlier. This holds for every beat of a burst.
- R3: Bursts of 1 to 64 beats come out in order with their payload intact. The write side carries 64-bit WDATA, WSTRB and WLAST. The read side carries RDATA, RID, RRESP and RLAST. LAST is set on the final beat of each burst only.
- R4: Each direction holds one beat at a time. The input ready is low from the cycle after a beat is accepted until the cycle after that beat's output handshake, and it is high again in that later cycle.
- R5: While an output valid is high and its ready is low, the output payload and LAST do not change.
- R6: The AW, AR and B channels pass through without delay. Valid and payload go forward and ready comes back. This holds even while a data beat is being held.
- R7: While `rst_n` is low, both output data valids are low and both input data readies are high. No beat held before reset is ever delivered.
- R8: Once an output data valid is high, it stays high until the receiver asserts ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awid | input | ID_W | Write address ID from master |
| s_awaddr | input | ADDR_W | Write address from master |
| s_awlen | input | LEN_W | Write burst length from master |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_wdata | input | DATA_W | Write data from master |
| s_wstrb | input | DATA_W/8 | Write strobes from master |
| s_wlast | input | 1 | Last write beat from master |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_bid | output | ID_W | Write response ID to master |
| s_bresp | output | 2 | Write response code to master |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_arid | input | ID_W | Read address ID from master |
| s_araddr | input | ADDR_W | Read address from master |
| s_arlen | input | LEN_W | Read burst length from master |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_rid | output | ID_W | Read data ID to master |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| s_rlast | output | 1 | Last read beat to master |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| m_awid | output | ID_W | Write address ID to slave |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_awlen | output | LEN_W | Write burst length to slave |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Write address ready from slave |
| m_wdata | output | DATA_W | Delayed write data to slave |
| m_wstrb | output | DATA_W/8 | Delayed write strobes to slave |
| m_wlast | output | 1 | Delayed last write beat to slave |
| m_wvalid | output | 1 | Delayed write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_bid | input | ID_W | Write response ID from slave |
| m_bresp | input | 2 | Write response code from slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready to slave |
| m_arid | output | ID_W | Read address ID to slave |
| m_araddr | output | ADDR_W | Read address to slave |
| m_arlen | output | LEN_W | Read burst length to slave |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Read address ready from slave |
| m_rid | input | ID_W | Read data ID from slave |
| m_rdata | input | DATA_W | Read data from slave |
| m_rresp | input | 2 | Read response code from slave |
| m_rlast | input | 1 | Last read beat from slave |
| m_rvalid | input | 1 | Read data valid from slave |
| m_rready | output | 1 | Read data ready to slave |

## Verification
The assertions check the following on every cycle in each holding stage:
- no beat appears at the output in the cycle after its acceptance;
- the input closes after an acceptance and reopens once the output handshake completes;
- the output valid stays high until it is taken;
- the payload stays stable under backpressure.

Only the bench scenarios can show the rest:
- the exact DELAY-cycle gap per beat;
- in-order delivery and LAST placement across every burst length from 1 to 64, under three ready patterns;
- the pass-through of the address and response channels while a beat is held;
- that a reset discards a held beat.

// File: rtl/bds_pkg.sv
package bds_pkg;

  parameter int unsigned RESP_W = 2;

  // Width of a counter that must reach the value d.
  function automatic int cnt_bits(input int d);
    return (d < 2) ? 1 : $clog2(d + 1);
  endfunction

endpackage

// File: rtl/bds_chan_pass.sv
// Zero-latency channel pass-through: valid/payload forward, ready back.
module bds_chan_pass #(
  parameter int unsigned PW = 8
) (
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  always_comb begin
    out_valid = in_valid;
    out_data  = in_data;
    in_ready  = out_ready;
  end

endmodule

// File: rtl/bds_delay_stage.sv
// One-entry holding stage that releases its beat DELAY cycles after capture.
module bds_delay_stage #(
  parameter int unsigned PW    = 65,
  parameter int unsigned DELAY = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  localparam int unsigned CNT_W = bds_pkg::cnt_bits(DELAY);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DELAY);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    hold_q;
  logic             take, give;

  assign in_ready  = !busy_q;
  assign out_valid = busy_q && (cnt_q == CNT_END);
  assign out_data  = hold_q;
  assign take      = in_valid && !busy_q;
  assign give      = out_valid && out_ready;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (take) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (give) begin
      busy_d = 1'b0;
    end else if (busy_q && (cnt_q != CNT_END)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Payload register: clock-enabled on capture only.
  always_ff @(posedge clk) begin
    if (take) begin
      hold_q <= in_data;
    end
  end

  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid); // R1 R2
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R4
  AST_SLOT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R4
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R8
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R5

endmodule

// File: rtl/axi_beat_delay_slice.sv
module axi_beat_delay_slice #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DELAY  = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ID_W-1:0]            s_awid,
  input  logic [ADDR_W-1:0]          s_awaddr,
  input  logic [LEN_W-1:0]           s_awlen,
  input  logic                       s_awvalid,
  output logic                       s_awready,
  input  logic [DATA_W-1:0]          s_wdata,
  input  logic [DATA_W/8-1:0]        s_wstrb,
  input  logic                       s_wlast,
  input  logic                       s_wvalid,
  output logic                       s_wready,
  output logic [ID_W-1:0]            s_bid,
  output logic [bds_pkg::RESP_W-1:0] s_bresp,
  output logic                       s_bvalid,
  input  logic                       s_bready,
  input  logic [ID_W-1:0]            s_arid,
  input  logic [ADDR_W-1:0]          s_araddr,
  input  logic [LEN_W-1:0]           s_arlen,
  input  logic                       s_arvalid,
  output logic                       s_arready,
  output logic [ID_W-1:0]            s_rid,
  output logic [DATA_W-1:0]          s_rdata,
  output logic [bds_pkg::RESP_W-1:0] s_rresp,
  output logic                       s_rlast,
  output logic                       s_rvalid,
  input  logic                       s_rready,
  output logic [ID_W-1:0]            m_awid,
  output logic [ADDR_W-1:0]          m_awaddr,
  output logic [LEN_W-1:0]           m_awlen,
  output logic                       m_awvalid,
  input  logic                       m_awready,
  output logic [DATA_W-1:0]          m_wdata,
  output logic [DATA_W/8-1:0]        m_wstrb,
  output logic                       m_wlast,
  output logic                       m_wvalid,
  input  logic                       m_wready,
  input  logic [ID_W-1:0]            m_bid,
  input  logic [bds_pkg::RESP_W-1:0] m_bresp,
  input  logic                       m_bvalid,
  output logic                       m_bready,
  output logic [ID_W-1:0]            m_arid,
  output logic [ADDR_W-1:0]          m_araddr,
  output logic [LEN_W-1:0]           m_arlen,
  output logic                       m_arvalid,
  input  logic                       m_arready,
  input  logic [ID_W-1:0]            m_rid,
  input  logic [DATA_W-1:0]          m_rdata,
  input  logic [bds_pkg::RESP_W-1:0] m_rresp,
  input  logic                       m_rlast,
  input  logic                       m_rvalid,
  output logic                       m_rready
);

  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned RSP_W  = bds_pkg::RESP_W;
  localparam int unsigned AX_PW  = ID_W + ADDR_W + LEN_W;
  localparam int unsigned B_PW   = ID_W + RSP_W;
  localparam int unsigned W_PW   = STRB_W + 1 + DATA_W;
  localparam int unsigned R_PW   = ID_W + RSP_W + 1 + DATA_W;

  // Address and response channels: straight wires.
  bds_chan_pass #(.PW(AX_PW)) u_aw_pass (
    .in_valid (s_awvalid), .in_ready (s_awready),
    .in_data  ({s_awid, s_awaddr, s_awlen}),
    .out_valid(m_awvalid), .out_ready(m_awready),
    .out_data ({m_awid, m_awaddr, m_awlen})
  );

  bds_chan_pass #(.PW(AX_PW)) u_ar_pass (
    .in_valid (s_arvalid), .in_ready (s_arready),
    .in_data  ({s_arid, s_araddr, s_arlen}),
    .out_valid(m_arvalid), .out_ready(m_arready),
    .out_data ({m_arid, m_araddr, m_arlen})
  );

  bds_chan_pass #(.PW(B_PW)) u_b_pass (
    .in_valid (m_bvalid), .in_ready (m_bready),
    .in_data  ({m_bid, m_bresp}),
    .out_valid(s_bvalid), .out_ready(s_bready),
    .out_data ({s_bid, s_bresp})
  );

  // Data channels: per-beat delay.
  bds_delay_stage #(.PW(W_PW), .DELAY(DELAY)) u_w_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_wvalid),
    .in_ready (s_wready),
    .in_data  ({s_wstrb, s_wlast, s_wdata}),
    .out_valid(m_wvalid),
    .out_ready(m_wready),
    .out_data ({m_wstrb, m_wlast, m_wdata})
  );

  bds_delay_stage #(.PW(R_PW), .DELAY(DELAY)) u_r_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (m_rvalid),
    .in_ready (m_rready),
    .in_data  ({m_rid, m_rresp, m_rlast, m_rdata}),
    .out_valid(s_rvalid),
    .out_ready(s_rready),
    .out_data ({s_rid, s_rresp, s_rlast, s_rdata})
  );

endmodule

// File: tb/axi_beat_delay_slice_tb.sv
`timescale 1ns/1ps
module axi_beat_delay_slice_tb;

  localparam int DLY     = 15;
  localparam int MAX_LEN = 64;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  int w_acc[$];
  int r_acc[$];

  logic [3:0]  s_awid, s_arid, m_awid, m_arid, s_bid, m_bid, s_rid, m_rid;
  logic [31:0] s_awaddr, s_araddr, m_awaddr, m_araddr;
  logic [7:0]  s_awlen, s_arlen, m_awlen, m_arlen;
  logic        s_awvalid, s_awready, m_awvalid, m_awready;
  logic        s_arvalid, s_arready, m_arvalid, m_arready;
  logic [1:0]  s_bresp, m_bresp, s_rresp, m_rresp;
  logic        s_bvalid, s_bready, m_bvalid, m_bready;
  logic [63:0] s_wdata, m_wdata, s_rdata, m_rdata;
  logic [7:0]  s_wstrb, m_wstrb;
  logic        s_wlast, m_wlast, s_wvalid, s_wready, m_wvalid, m_wready;
  logic        s_rlast, m_rlast, s_rvalid, s_rready, m_rvalid, m_rready;

  axi_beat_delay_slice u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bid(m_bid), .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rid(m_rid), .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] wdat(input int len, input int idx);
    return {32'(len) ^ 32'hA5A5_0000, 32'(idx) * 32'h9E37_79B9};
  endfunction
  function automatic logic [63:0] rdat(input int len, input int idx);
    return {32'(idx) ^ 32'h5A5A_1234, 32'(len) * 32'h0131_7F03};
  endfunction
  function automatic logic [7:0] wstb(input int len, input int idx);
    return 8'(len * idx + 1);
  endfunction

  // Receiver ready pattern chosen per burst length.
  function automatic logic rdy(input int len, input int c);
    case (len % 3)
      0:       return 1'b1;
      1:       return (c % 3) == 0;
      default: return ((c * 13) >> 2) % 2 == 1;
    endcase
  endfunction
  function automatic bit gap(input int len, input int c);
    return (len % 3 == 2) && (c % 4 == 1);
  endfunction

  task automatic drive_w();
    int len = 1;
    int idx = 0;
    bit hs = 0;
    while (len <= MAX_LEN) begin
      @(negedge clk);
      if (hs) begin
        hs = 0; s_wvalid = 1'b0; idx++;
        if (idx == len) begin len++; idx = 0; end
      end
      if (len > MAX_LEN) break;
      if (!s_wvalid && !gap(len, cyc)) begin
        s_wvalid = 1'b1; s_wdata = wdat(len, idx);
        s_wstrb = wstb(len, idx); s_wlast = (idx == len - 1);
      end
      if (s_wvalid && s_wready) begin hs = 1; w_acc.push_back(cyc); end
    end
    s_wvalid = 1'b0;
  endtask

  task automatic drive_r();
    int len = 1;
    int idx = 0;
    bit hs = 0;
    while (len <= MAX_LEN) begin
      @(negedge clk);
      if (hs) begin
        hs = 0; m_rvalid = 1'b0; idx++;
        if (idx == len) begin len++; idx = 0; end
      end
      if (len > MAX_LEN) break;
      if (!m_rvalid && !gap(len + 1, cyc)) begin
        m_rvalid = 1'b1; m_rdata = rdat(len, idx); m_rid = 4'(len);
        m_rresp = 2'(idx); m_rlast = (idx == len - 1);
      end
      if (m_rvalid && m_rready) begin hs = 1; r_acc.push_back(cyc); end
    end
    m_rvalid = 1'b0;
  endtask

  task automatic sink_w();
    int len = 1;
    int idx = 0;
    bit seen = 0;
    int a;
    while (len <= MAX_LEN) begin
      @(negedge clk);
      if (m_wvalid && !seen) begin
        seen = 1;
        a = (w_acc.size() > 0) ? w_acc.pop_front() : -100;
        chk(cyc == a + DLY, "R1 write beat delay", cyc, a + DLY);
        chk(m_wdata == wdat(len, idx), "R3 write data order", m_wdata, wdat(len, idx));
        chk(m_wstrb == wstb(len, idx), "R3 write strobe", m_wstrb, wstb(len, idx));
        chk(m_wlast == (idx == len - 1), "R3 write last", m_wlast, (idx == len - 1));
      end else if (seen) begin
        chk(m_wvalid, "R8 write valid held", m_wvalid, 1);
      end
      m_wready = rdy(len, cyc);
      if (m_wvalid && m_wready) begin
        seen = 0; idx++;
        if (idx == len) begin len++; idx = 0; end
      end
    end
    m_wready = 1'b0;
  endtask

  task automatic sink_r();
    int len = 1;
    int idx = 0;
    bit seen = 0;
    int a;
    while (len <= MAX_LEN) begin
      @(negedge clk);
      if (s_rvalid && !seen) begin
        seen = 1;
        a = (r_acc.size() > 0) ? r_acc.pop_front() : -100;
        chk(cyc == a + DLY, "R2 read beat delay", cyc, a + DLY);
        chk(s_rdata == rdat(len, idx), "R3 read data order", s_rdata, rdat(len, idx));
        chk(s_rid == 4'(len), "R3 read id", s_rid, 4'(len));
        chk(s_rresp == 2'(idx), "R3 read resp", s_rresp, 2'(idx));
        chk(s_rlast == (idx == len - 1), "R3 read last", s_rlast, (idx == len - 1));
      end else if (seen) begin
        chk(s_rvalid, "R8 read valid held", s_rvalid, 1);
      end
      s_rready = rdy(len + 2, cyc);
      if (s_rvalid && s_rready) begin
        seen = 0; idx++;
        if (idx == len) begin len++; idx = 0; end
      end
    end
    s_rready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    s_awvalid = 0; s_awid = 0; s_awaddr = 0; s_awlen = 0;
    s_arvalid = 0; s_arid = 0; s_araddr = 0; s_arlen = 0;
    m_awready = 0; m_arready = 0;
    m_bvalid = 0; m_bid = 0; m_bresp = 0; s_bready = 0;
    s_wvalid = 0; s_wdata = 0; s_wstrb = 0; s_wlast = 0; m_wready = 0;
    m_rvalid = 0; m_rdata = 0; m_rid = 0; m_rresp = 0; m_rlast = 0; s_rready = 0;
    repeat (3) @(negedge clk);
    chk(!m_wvalid && !s_rvalid, "R7 reset valids low", {m_wvalid, s_rvalid}, 0);
    chk(s_wready && m_rready, "R7 reset readies high", {s_wready, m_rready}, 3);
    rst_n = 1'b1;
    @(negedge clk);

    fork
      drive_w();
      sink_w();
      drive_r();
      sink_r();
    join

    // Pass-through channels while a write beat is held.
    @(negedge clk);
    s_wvalid = 1'b1; s_wdata = 64'hDEAD_BEEF_0000_0001; s_wstrb = 8'hFF; s_wlast = 1'b1;
    @(negedge clk);
    s_wvalid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!s_wready, "R4 input closed while holding", s_wready, 0);
    s_awvalid = 1'b1; s_awid = 4'h9; s_awaddr = 32'h1234_5678; s_awlen = 8'd63; m_awready = 1'b1;
    #1;
    chk(m_awvalid && m_awaddr == 32'h1234_5678 && m_awid == 4'h9 && m_awlen == 8'd63,
        "R6 aw forward", m_awaddr, 32'h1234_5678);
    chk(s_awready, "R6 aw ready back", s_awready, 1);
    m_awready = 1'b0; #1;
    chk(!s_awready, "R6 aw ready low back", s_awready, 0);
    s_arvalid = 1'b1; s_araddr = 32'hCAFE_0040; s_arid = 4'h3; s_arlen = 8'd7; m_arready = 1'b1;
    #1;
    chk(m_arvalid && m_araddr == 32'hCAFE_0040 && m_arid == 4'h3 && s_arready,
        "R6 ar forward", m_araddr, 32'hCAFE_0040);
    m_bvalid = 1'b1; m_bid = 4'h5; m_bresp = 2'd2; s_bready = 1'b1;
    #1;
    chk(s_bvalid && s_bid == 4'h5 && s_bresp == 2'd2 && m_bready, "R6 b backward",
        {s_bid, s_bresp}, {4'h5, 2'd2});
    s_awvalid = 0; s_arvalid = 0; m_bvalid = 0; s_bready = 0; m_arready = 0;

    // Reset while the beat is held: it must never appear.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!m_wvalid && s_wready, "R7 reset clears held beat", {m_wvalid, s_wready}, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_wready = 1'b1;
    for (int i = 0; i < DLY + 5; i++) begin
      @(negedge clk);
      if (m_wvalid) chk(0, "R7 held beat dropped by reset", m_wvalid, 0);
    end
    chk(!m_wvalid && s_wready, "R7 idle after reset", {m_wvalid, s_wready}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule